// File: doc/BRIEF.md
# Shared Four-Band Triangular Carrier Generator

This block drives the carriers that every phase modulator of a five-level-per-phase PWM controller compares its references against. One up/down counter ramps from zero to a programmable peak and back. From that single count the block derives four carrier values, one per voltage band, and inverts some of them according to the selected placement scheme. The shared count means that all three phases and all four bands stay locked to the same timebase.

The programmable peak sets the switching frequency, because one carrier period lasts twice the peak count in clocks. Three placements are offered. In the first, every carrier is in phase. In the second, the two upper-band carriers are mirrored against the two lower-band ones. In the third, neighbouring carriers are mirrored against each other. A space-vector mode overrides the selection and forces all carriers in phase. Single-cycle strobes mark the peak and the trough, and a sample strobe tells the reference latches when to capture. New settings are held back until the next trough, so a carrier period in progress always finishes with the settings it started with.

Top module: `mlc_carrier_gen`

## Requirements
- R1: While synchronous reset `rst_n` is low, the shared count is forced to 0 and rising, and the period, scheme, space-vector and asymmetric settings are captured from the inputs.
- R2: Out of reset, the count rises by one per clock from 0 to the active peak and then falls by one per clock back to 0, so one carrier period lasts 2 × peak clocks.
- R3: A `period_i` value of 0 is taken as a peak of 1, which gives a 2-clock carrier period.
- R4: The settings are captured only on the clock edge where the count steps from 1 down to 0, and during reset. Input changes at any other time have no effect until that edge.
- R5: Scheme code 0 (and the unused code 3) puts all carriers in phase, so every carrier equals the count.
- R6: Scheme code 1 inverts the upper half of the carriers (indices 2 and 3) to peak − count, and the lower half follows the count.
- R7: Scheme code 2 inverts the odd-indexed carriers (1 and 3) to peak − count, and the even-indexed carriers follow the count.
- R8: When `svm_i` is active, all carriers are in phase whatever the scheme code is.
- R9: `peak_o` is high only in cycles where the count equals the active peak, and `trough_o` is high only where the count is 0.
- R10: `sample_o` follows `peak_o` in space-vector mode. Otherwise it follows `trough_o` when `asym_i` is low, and `peak_o | trough_o` when `asym_i` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| period_i | input | CNT_W | Requested peak count (carrier half-period) |
| scheme_i | input | 2 | Placement code: 0 in phase, 1 halves mirrored, 2 neighbours mirrored, 3 as 0 |
| svm_i | input | 1 | Space-vector mode: forces in-phase carriers and peak sampling |
| asym_i | input | 1 | Sample at both peak and trough when high |
| carrier_o | output | NUM_CARRIERS×CNT_W | Carrier k occupies bits [k×CNT_W +: CNT_W], with k=0 the lowest band |
| peak_o | output | 1 | Peak strobe |
| trough_o | output | 1 | Trough strobe |
| sample_o | output | 1 | Reference sampling strobe |

## Verification
The properties assume that reset is held for at least one clock edge, so that the captured settings are defined before they are checked. They also rely on the active peak never being zero, which the clamp in R3 guarantees, so a peak and a trough never fall in the same cycle. The stimulus changes inputs only on falling clock edges. It applies zero and one as requested periods and changes the period partway through a ramp to exercise the deferred capture. It steps through every scheme code both with and without space-vector mode.

// File: rtl/mlc_carrier_pkg.sv
package mlc_carrier_pkg;

    // Placement of the carriers relative to each other
    typedef enum logic [1:0] {
        PLACE_INPHASE = 2'd0,
        PLACE_HALVES  = 2'd1,
        PLACE_ALTERN  = 2'd2,
        PLACE_SPARE   = 2'd3
    } place_e;

endpackage

// File: rtl/carrier_timebase.sv
module carrier_timebase
    import mlc_carrier_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] period_i,
    input  place_e           scheme_i,
    input  logic             svm_i,
    input  logic             asym_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] max_o,
    output place_e           scheme_o,
    output logic             svm_o,
    output logic             asym_o
);

    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             up;
        logic [CNT_W-1:0] max;
        place_e           scheme;
        logic             svm;
        logic             asym;
    } tb_state_t;

    tb_state_t        st_d, st_q;
    logic [CNT_W-1:0] per_eff_d;
    logic             reload_d;

    always_comb begin
        st_d      = st_q;
        reload_d  = 1'b0;
        per_eff_d = (period_i == '0) ? ONE : period_i;

        if (st_q.up) begin
            st_d.cnt = st_q.cnt + ONE;
            if (st_q.cnt + ONE == st_q.max) begin
                st_d.up = 1'b0;
            end
        end else begin
            st_d.cnt = st_q.cnt - ONE;
            if (st_q.cnt == ONE) begin
                st_d.up  = 1'b1;
                reload_d = 1'b1;
            end
        end

        if (reload_d || !rst_n) begin
            st_d.max    = per_eff_d;
            st_d.scheme = scheme_i;
            st_d.svm    = svm_i;
            st_d.asym   = asym_i;
        end

        if (!rst_n) begin
            st_d.cnt = '0;
            st_d.up  = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign cnt_o    = st_q.cnt;
    assign max_o    = st_q.max;
    assign scheme_o = st_q.scheme;
    assign svm_o    = st_q.svm;
    assign asym_o   = st_q.asym;

endmodule

// File: rtl/carrier_arrange.sv
module carrier_arrange
    import mlc_carrier_pkg::*;
#(
    parameter int CNT_W        = 16,
    parameter int NUM_CARRIERS = 4
) (
    input  logic [CNT_W-1:0]              cnt_i,
    input  logic [CNT_W-1:0]              max_i,
    input  place_e                        scheme_i,
    input  logic                          svm_i,
    output logic [NUM_CARRIERS*CNT_W-1:0] carrier_o
);

    localparam int HALF = NUM_CARRIERS / 2;

    logic [CNT_W-1:0] mirror_w;
    assign mirror_w = max_i - cnt_i;

    for (genvar k = 0; k < NUM_CARRIERS; k++) begin : g_band
        logic inv_d;
        always_comb begin
            inv_d = 1'b0;
            if (!svm_i) begin
                case (scheme_i)
                    PLACE_HALVES: inv_d = (k >= HALF);
                    PLACE_ALTERN: inv_d = ((k % 2) == 1);
                    default:      inv_d = 1'b0;
                endcase
            end
        end
        assign carrier_o[k*CNT_W +: CNT_W] = inv_d ? mirror_w : cnt_i;
    end

endmodule

// File: rtl/carrier_strobes.sv
module carrier_strobes #(
    parameter int CNT_W = 16
) (
    input  logic [CNT_W-1:0] cnt_i,
    input  logic [CNT_W-1:0] max_i,
    input  logic             svm_i,
    input  logic             asym_i,
    output logic             peak_o,
    output logic             trough_o,
    output logic             sample_o
);

    always_comb begin
        peak_o   = (cnt_i == max_i);
        trough_o = (cnt_i == '0);
        if (svm_i) begin
            sample_o = peak_o;
        end else if (asym_i) begin
            sample_o = peak_o | trough_o;
        end else begin
            sample_o = trough_o;
        end
    end

endmodule

// File: rtl/mlc_carrier_gen.sv
module mlc_carrier_gen
    import mlc_carrier_pkg::*;
#(
    parameter int CNT_W        = 16,
    parameter int NUM_CARRIERS = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [CNT_W-1:0]              period_i,
    input  logic [1:0]                    scheme_i,
    input  logic                          svm_i,
    input  logic                          asym_i,
    output logic [NUM_CARRIERS*CNT_W-1:0] carrier_o,
    output logic                          peak_o,
    output logic                          trough_o,
    output logic                          sample_o
);

    logic [CNT_W-1:0] cnt_w;
    logic [CNT_W-1:0] max_w;
    place_e           scheme_w;
    logic             svm_w;
    logic             asym_w;

    carrier_timebase #(.CNT_W(CNT_W)) u_base (
        .clk      (clk),
        .rst_n    (rst_n),
        .period_i (period_i),
        .scheme_i (place_e'(scheme_i)),
        .svm_i    (svm_i),
        .asym_i   (asym_i),
        .cnt_o    (cnt_w),
        .max_o    (max_w),
        .scheme_o (scheme_w),
        .svm_o    (svm_w),
        .asym_o   (asym_w)
    );

    carrier_arrange #(.CNT_W(CNT_W), .NUM_CARRIERS(NUM_CARRIERS)) u_arr (
        .cnt_i     (cnt_w),
        .max_i     (max_w),
        .scheme_i  (scheme_w),
        .svm_i     (svm_w),
        .carrier_o (carrier_o)
    );

    carrier_strobes #(.CNT_W(CNT_W)) u_strb (
        .cnt_i    (cnt_w),
        .max_i    (max_w),
        .svm_i    (svm_w),
        .asym_i   (asym_w),
        .peak_o   (peak_o),
        .trough_o (trough_o),
        .sample_o (sample_o)
    );

endmodule

// File: rtl/mlc_carrier_gen_chk.sv
module mlc_carrier_gen_chk #(
    parameter int CNT_W        = 16,
    parameter int NUM_CARRIERS = 4
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic [CNT_W-1:0]              cnt,
    input logic [CNT_W-1:0]              act_max,
    input logic [1:0]                    act_scheme,
    input logic                          act_svm,
    input logic                          act_asym,
    input logic [NUM_CARRIERS*CNT_W-1:0] carrier,
    input logic                          peak,
    input logic                          trough,
    input logic                          sample
);

    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};
    localparam int LAST = NUM_CARRIERS - 1;

    logic past_valid_q;
    always_ff @(posedge clk) begin
        past_valid_q <= rst_n;
    end

    logic [CNT_W-1:0] c_first, c_second, c_last;
    assign c_first  = carrier[0 +: CNT_W];
    assign c_second = carrier[CNT_W +: CNT_W];
    assign c_last   = carrier[LAST*CNT_W +: CNT_W];

    assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        past_valid_q |-> (cnt == $past(cnt) + ONE) || (cnt == $past(cnt) - ONE));

    assert_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= act_max);

    assert_no_zero_peak_R3: assert property (@(posedge clk) disable iff (!rst_n)
        act_max != '0);

    assert_reload_at_trough_R4: assert property (@(posedge clk) disable iff (!rst_n)
        past_valid_q && (act_max != $past(act_max) || act_scheme != $past(act_scheme))
        |-> cnt == '0);

    assert_halves_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (act_scheme == 2'd1 && !act_svm) |-> (c_first + c_last == act_max));

    assert_neighbour_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (act_scheme == 2'd2 && !act_svm) |-> (c_first + c_second == act_max));

    assert_inphase_R8: assert property (@(posedge clk) disable iff (!rst_n)
        act_svm |-> (c_first == c_last));

    assert_strobe_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(peak && trough));

    assert_peak_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        peak |=> !peak);

    assert_svm_no_trough_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (act_svm && trough) |-> !sample);

    assert_sym_no_peak_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!act_svm && !act_asym && peak) |-> !sample);

endmodule

bind mlc_carrier_gen mlc_carrier_gen_chk #(
    .CNT_W        (CNT_W),
    .NUM_CARRIERS (NUM_CARRIERS)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cnt        (cnt_w),
    .act_max    (max_w),
    .act_scheme (scheme_w),
    .act_svm    (svm_w),
    .act_asym   (asym_w),
    .carrier    (carrier_o),
    .peak       (peak_o),
    .trough     (trough_o),
    .sample     (sample_o)
);

// File: tb/mlc_carrier_gen_tb.sv
module mlc_carrier_gen_tb;

    localparam int CLK_PERIOD = 10;
    localparam int W  = 16;
    localparam int NC = 4;

    logic              clk = 1'b0;
    logic              rst_n;
    logic [W-1:0]      period_i;
    logic [1:0]        scheme_i;
    logic              svm_i;
    logic              asym_i;
    logic [NC*W-1:0]   carrier_o;
    logic              peak_o, trough_o, sample_o;

    always #(CLK_PERIOD/2) clk = ~clk;

    mlc_carrier_gen #(.CNT_W(W), .NUM_CARRIERS(NC)) u_dut (
        .clk(clk), .rst_n(rst_n), .period_i(period_i), .scheme_i(scheme_i),
        .svm_i(svm_i), .asym_i(asym_i), .carrier_o(carrier_o),
        .peak_o(peak_o), .trough_o(trough_o), .sample_o(sample_o)
    );

    typedef struct {
        logic [NC*W-1:0] car;
        logic            peak;
        logic            trough;
        logic            sample;
        string           tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_tests = 0;
    int   n_fail  = 0;
    bit   done    = 1'b0;

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Reference model built from the requirements
    int  m_cnt, m_max, m_sch;
    bit  m_up, m_svm, m_asym, m_zero, m_rst;

    task automatic m_load();
        m_zero = (period_i == '0);
        m_max  = m_zero ? 1 : int'(period_i);
        m_sch  = int'(scheme_i);
        m_svm  = svm_i;
        m_asym = asym_i;
    endtask

    always @(posedge clk) begin
        exp_t e;
        int   sch;
        m_rst = !rst_n;
        if (!rst_n) begin
            m_cnt = 0; m_up = 1'b1; m_load();
        end else if (m_up) begin
            m_cnt++;
            if (m_cnt == m_max) m_up = 1'b0;
        end else begin
            m_cnt--;
            if (m_cnt == 0) begin m_up = 1'b1; m_load(); end
        end
        sch = (m_svm || m_sch == 3) ? 0 : m_sch;
        for (int k = 0; k < NC; k++) begin
            bit inv;
            inv = (sch == 1) ? (k >= NC/2) : (sch == 2) ? (k % 2 == 1) : 1'b0;
            e.car[k*W +: W] = inv ? W'(m_max - m_cnt) : W'(m_cnt);
        end
        e.peak   = (m_cnt == m_max);
        e.trough = (m_cnt == 0);
        e.sample = m_svm ? e.peak : (m_asym ? (e.peak | e.trough) : e.trough);
        if (m_rst)           e.tag = "R1";
        else if (m_svm)      e.tag = "R8 R2 R4";
        else if (sch == 1)   e.tag = "R6 R2 R4";
        else if (sch == 2)   e.tag = "R7 R2 R4";
        else                 e.tag = "R5 R2 R4";
        if (m_zero) e.tag = {e.tag, " R3"};
        exp_q.push_back(e);
    end

    // Monitor: compare away from the active edge
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            check(carrier_o === e.car, {"carriers ", e.tag}, 64'(carrier_o), 64'(e.car));
            check(peak_o === e.peak && trough_o === e.trough, "strobes R9",
                  {62'd0, peak_o, trough_o}, {62'd0, e.peak, e.trough});
            check(sample_o === e.sample, "sample R10", 64'(sample_o), 64'(e.sample));
        end
    end

    task automatic wait_trough();
        do @(negedge clk); while (!trough_o);
    endtask

    task automatic wait_peak();
        do @(negedge clk); while (!peak_o);
    endtask

    task automatic measure_period(input int exp, input string req);
        int n;
        wait_trough();
        n = 0;
        do begin @(negedge clk); n++; end while (!trough_o);
        check(n == exp, req, 64'(n), 64'(exp));
    endtask

    task automatic settle();
        wait_trough();
        wait_trough();
    endtask

    initial begin
        rst_n = 1'b0; period_i = W'(5); scheme_i = 2'd0; svm_i = 1'b0; asym_i = 1'b0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(carrier_o == '0 && trough_o && !peak_o, "reset R1", 64'(carrier_o), 64'd0);
        rst_n = 1'b1;

        // R2: period length at peak 5
        measure_period(10, "period R2");

        // R6 with asymmetric sampling (R10)
        scheme_i = 2'd1; asym_i = 1'b1;
        settle(); repeat (24) @(negedge clk);

        // R7
        scheme_i = 2'd2; asym_i = 1'b0;
        settle(); repeat (24) @(negedge clk);

        // R8: space-vector overrides scheme code 1
        scheme_i = 2'd1; svm_i = 1'b1;
        settle(); repeat (24) @(negedge clk);

        // R5 with the unused code 3
        scheme_i = 2'd3; svm_i = 1'b0; asym_i = 1'b1;
        settle(); repeat (24) @(negedge clk);

        // R4: a period change partway through a ramp waits for the trough
        scheme_i = 2'd0; asym_i = 1'b0; period_i = W'(5);
        settle();
        @(negedge clk);
        period_i = W'(9);
        wait_peak();
        check(carrier_o[0 +: W] == W'(5), "deferred reload R4", 64'(carrier_o[0 +: W]), 64'd5);
        wait_peak();
        check(carrier_o[0 +: W] == W'(9), "new peak R4", 64'(carrier_o[0 +: W]), 64'd9);

        // R3: zero and one both give a 2-clock period
        period_i = W'(0);
        settle();
        measure_period(2, "zero period R3");
        period_i = W'(1);
        settle();
        measure_period(2, "unit period R3");

        // R2: longer period, neighbour scheme
        period_i = W'(40); scheme_i = 2'd2;
        settle();
        measure_period(80, "period R2");

        // R1: reset in mid-ramp with halves scheme and peak 7
        scheme_i = 2'd1; period_i = W'(7);
        repeat (13) @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check(carrier_o[LAST_IDX*W +: W] == W'(7) && carrier_o[0 +: W] == '0, "reset R1",
              64'(carrier_o), 64'd7);
        rst_n = 1'b1;
        repeat (30) @(negedge clk);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    localparam int LAST_IDX = NC - 1;

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog R2 actual=%0d expected=%0d", 1, 0);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule